// File: doc/BRIEF.md
# Byte-Read Sample Buffer with Threshold Events

This block holds 16-bit conversion results in a first-in first-out store of 4096 bytes (2048 samples). A converter pushes one whole sample per cycle. A host takes samples out one byte at a time through a single data port: the first byte it reads is the low half of the oldest sample, and the second byte is the high half. The sample leaves the store only when its high byte has been read. The host also writes to the same data port to program thresholds. After a buffer clear, the first four bytes it writes there are configuration bytes.

A status byte combines level bits, which follow the buffer at all times, with sticky event bits, which are cleared when the host reads the status byte. The near-full threshold is given as a number of free bytes, not as a fill level. The threshold event fires when the free space drops to that number or below. An interrupt line is raised for each pending event whose enable input is high.

Top module: `smpl_fifo`

## Requirements
- R1: After reset, with `acq_run` low, `sts_byte` reads 8'h81 (idle and empty set, every other bit clear) and `irq` is low.
- R2: Samples come out in arrival order, and each sample takes two `dat_rd` strobes: `dat_rdata` shows bits 7:0 first and bits 15:8 second.
- R3: The buffer holds 2048 samples, and status bit 2 (full) is set exactly when 2048 samples are stored. A sample pushed while the buffer is full is discarded, and status bit 5 (data lost) is set.
- R4: After a clear, the first four `dat_wr` bytes are configuration. Bytes one and two (the near-empty value, low byte first) have no effect. Bytes three and four are the near-full free-byte count, low byte then high byte. Any later data writes are ignored until the next clear.
- R5: Status bit 1 (near full) is high while the free bytes are at or below the near-full count. Free bytes are 4096 minus the stored bytes, and a sample whose low byte has already been read counts as one byte.
- R6: Status bit 3 (threshold) is set in the cycle after the near-full level goes from low to high.
- R7: Reading the status byte with `sts_rd` clears bits 5, 4 and 3. If an event arrives in the same cycle as the read, that bit stays set. Bits 2, 1 and 0 are not affected by the read.
- R8: A `scan_end` pulse sets status bit 4 (end of scan) on the next edge.
- R9: `irq` is high exactly when (`thr_irq_en` and bit 3) or (`eos_irq_en` and bit 4).
- R10: Status bit 7 is the inverse of `acq_run` and bit 6 follows `acq_run`. Bit 0 is set when no byte is stored.
- R11: A `dat_rd` while the buffer is empty has no effect, and the next sample pushed reads back correctly.
- R12: `fifo_clr` discards all stored data and takes priority over a push in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_run | input | 1 | Acquisition in progress (drives status bits 7 and 6) |
| smp_valid | input | 1 | Push `smp_data` this cycle |
| smp_data | input | 16 | Conversion result |
| scan_end | input | 1 | End-of-scan event pulse |
| fifo_clr | input | 1 | Clear stored data and restart the configuration byte sequence |
| dat_wr | input | 1 | Host byte write to the data port |
| dat_wdata | input | 8 | Host write byte |
| dat_rd | input | 1 | Host byte read strobe on the data port |
| dat_rdata | output | 8 | Byte currently presented to the host |
| sts_rd | input | 1 | Host read strobe for the status byte |
| sts_byte | output | 8 | Status byte |
| thr_irq_en | input | 1 | Interrupt enable for the threshold event |
| eos_irq_en | input | 1 | Interrupt enable for the end-of-scan event |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every strobe is a synchronous one-cycle-wide level and that `fifo_clr` is never raised together with a host byte read. They also assume that a push seen while the buffer is full takes place without a concurrent pop, whenever the stable-count property is expected to hold. The stimulus drives all inputs at the falling edge from one task per operation. It never overlaps a clear with a read, and it reaches the full buffer only through consecutive pushes with no host reads in between.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  localparam int unsigned SMP_W = 16;
  localparam int unsigned THR_W = 16;

  // status byte bit positions (host software decodes these)
  localparam int unsigned ST_IDLE = 7;
  localparam int unsigned ST_RUN  = 6;
  localparam int unsigned ST_LOST = 5;
  localparam int unsigned ST_EOS  = 4;
  localparam int unsigned ST_THR  = 3;
  localparam int unsigned ST_FULL = 2;
  localparam int unsigned ST_NF   = 1;
  localparam int unsigned ST_EMPT = 0;

  // event vector indices
  localparam int unsigned EV_THR  = 0;
  localparam int unsigned EV_EOS  = 1;
  localparam int unsigned EV_LOST = 2;
  localparam int unsigned EV_N    = 3;

  typedef enum logic [2:0] {
    CFG_NE_LO,
    CFG_NE_HI,
    CFG_NF_LO,
    CFG_NF_HI,
    CFG_DONE
  } cfg_state_t;
endpackage

// File: rtl/sfq_store.sv
module sfq_store
  import sfq_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [SMP_W-1:0] push_data,
  input  logic             rd_byte,
  output logic [7:0]       rd_data,
  output logic [CW-1:0]    cnt,
  output logic             half,
  output logic             full,
  output logic             dropped
);
  logic [SMP_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, wptr_n, rptr, rptr_n;
  logic [CW-1:0]    cnt_n;
  logic             half_n;
  logic             has, adv, pop, acc;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full    = (cnt == CW'(DEPTH));
    has     = (cnt != '0);
    adv     = rd_byte & has;
    pop     = adv & half;
    acc     = push & ~full & ~flush;
    dropped = push & full & ~flush;
    wptr_n  = wptr;
    rptr_n  = rptr;
    half_n  = half;
    cnt_n   = cnt;
    if (flush) begin
      wptr_n = '0;
      rptr_n = '0;
      half_n = 1'b0;
      cnt_n  = '0;
    end else begin
      if (acc) wptr_n = ptr_inc(wptr);
      if (pop) rptr_n = ptr_inc(rptr);
      if (adv) half_n = ~half;
      case ({acc, pop})
        2'b10:   cnt_n = cnt + 1'b1;
        2'b01:   cnt_n = cnt - 1'b1;
        default: cnt_n = cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      half <= 1'b0;
      cnt  <= '0;
    end else begin
      wptr <= wptr_n;
      rptr <= rptr_n;
      half <= half_n;
      cnt  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) mem[wptr] <= push_data;
  end

  assign rd_data = half ? mem[rptr][15:8] : mem[rptr][7:0];
endmodule

// File: rtl/sfq_cfg.sv
module sfq_cfg
  import sfq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr,
  input  logic [7:0]       wdata,
  output logic [THR_W-1:0] nf_thr
);
  cfg_state_t       st, st_n;
  logic [7:0]       lo_q, lo_n;
  logic [THR_W-1:0] thr_n;

  always_comb begin
    st_n  = st;
    lo_n  = lo_q;
    thr_n = nf_thr;
    if (flush) begin
      st_n = CFG_NE_LO;
    end else if (wr) begin
      case (st)
        CFG_NE_LO: st_n = CFG_NE_HI;
        CFG_NE_HI: st_n = CFG_NF_LO;
        CFG_NF_LO: begin
          lo_n = wdata;
          st_n = CFG_NF_HI;
        end
        CFG_NF_HI: begin
          thr_n = THR_W'({wdata, lo_q});
          st_n  = CFG_DONE;
        end
        default: st_n = CFG_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= CFG_NE_LO;
      lo_q   <= '0;
      nf_thr <= '0;
    end else begin
      st     <= st_n;
      lo_q   <= lo_n;
      nf_thr <= thr_n;
    end
  end
endmodule

// File: rtl/sfq_evt.sv
module sfq_evt
  import sfq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           nf_lvl,
  input  logic           lost_set,
  input  logic           eos_set,
  input  logic           sts_rd,
  input  logic           thr_en,
  input  logic           eos_en,
  output logic [EV_N-1:0] ev,
  output logic           irq
);
  logic            lvl_q;
  logic [EV_N-1:0] ev_set, ev_n;

  always_comb begin
    ev_set          = '0;
    ev_set[EV_THR]  = nf_lvl & ~lvl_q;
    ev_set[EV_EOS]  = eos_set;
    ev_set[EV_LOST] = lost_set;
  end

  for (genvar i = 0; i < EV_N; i++) begin : g_ev
    // a new event beats a concurrent clearing read
    assign ev_n[i] = ev_set[i] | (ev[i] & ~sts_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev    <= '0;
      lvl_q <= 1'b0;
    end else begin
      ev    <= ev_n;
      lvl_q <= nf_lvl;
    end
  end

  assign irq = (thr_en & ev[EV_THR]) | (eos_en & ev[EV_EOS]);
endmodule

// File: rtl/smpl_fifo.sv
module smpl_fifo
  import sfq_pkg::*;
#(
  parameter int unsigned DEPTH = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acq_run,
  input  logic        smp_valid,
  input  logic [15:0] smp_data,
  input  logic        scan_end,
  input  logic        fifo_clr,
  input  logic        dat_wr,
  input  logic [7:0]  dat_wdata,
  input  logic        dat_rd,
  output logic [7:0]  dat_rdata,
  input  logic        sts_rd,
  output logic [7:0]  sts_byte,
  input  logic        thr_irq_en,
  input  logic        eos_irq_en,
  output logic        irq
);
  localparam int unsigned CW        = $clog2(DEPTH + 1);
  localparam int unsigned CAP_BYTES = 2 * DEPTH;
  localparam int unsigned BW        = $clog2(CAP_BYTES + 1);

  logic [CW-1:0]    smp_cnt;
  logic             half, full, dropped, nf_lvl;
  logic [THR_W-1:0] nf_thr;
  logic [BW-1:0]    fill_b, free_b;
  logic [EV_N-1:0]  ev;

  sfq_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (fifo_clr),
    .push      (smp_valid),
    .push_data (smp_data),
    .rd_byte   (dat_rd),
    .rd_data   (dat_rdata),
    .cnt       (smp_cnt),
    .half      (half),
    .full      (full),
    .dropped   (dropped)
  );

  sfq_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (fifo_clr),
    .wr     (dat_wr),
    .wdata  (dat_wdata),
    .nf_thr (nf_thr)
  );

  always_comb begin
    fill_b = {smp_cnt, 1'b0} - BW'(half);
    free_b = BW'(CAP_BYTES) - fill_b;
    nf_lvl = (32'(free_b) <= 32'(nf_thr));
  end

  sfq_evt u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .nf_lvl   (nf_lvl),
    .lost_set (dropped),
    .eos_set  (scan_end),
    .sts_rd   (sts_rd),
    .thr_en   (thr_irq_en),
    .eos_en   (eos_irq_en),
    .ev       (ev),
    .irq      (irq)
  );

  always_comb begin
    sts_byte          = '0;
    sts_byte[ST_IDLE] = ~acq_run;
    sts_byte[ST_RUN]  = acq_run;
    sts_byte[ST_LOST] = ev[EV_LOST];
    sts_byte[ST_EOS]  = ev[EV_EOS];
    sts_byte[ST_THR]  = ev[EV_THR];
    sts_byte[ST_FULL] = full;
    sts_byte[ST_NF]   = nf_lvl;
    sts_byte[ST_EMPT] = (fill_b == '0);
  end
endmodule

// File: rtl/sfq_chk.sv
module sfq_chk #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          scan_end,
  input logic          fifo_clr,
  input logic          dat_rd,
  input logic          sts_rd,
  input logic [7:0]    sts_byte,
  input logic          thr_irq_en,
  input logic          eos_irq_en,
  input logic          irq,
  input logic [CW-1:0] cnt
);
  assert_lost_on_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && sts_byte[2] && !fifo_clr) |=> sts_byte[5]);

  assert_drop_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && sts_byte[2] && !fifo_clr && !dat_rd) |=> $stable(cnt));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_eos_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && !scan_end) |=> !sts_byte[4]);

  assert_eos_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_end |=> sts_byte[4]);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_irq_en && !eos_irq_en) |-> !irq);

  assert_run_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sts_byte[7:6]));

  assert_empty_not_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts_byte[0] && sts_byte[2]));

  assert_clear_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> sts_byte[0]);
endmodule

bind smpl_fifo sfq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .scan_end   (scan_end),
  .fifo_clr   (fifo_clr),
  .dat_rd     (dat_rd),
  .sts_rd     (sts_rd),
  .sts_byte   (sts_byte),
  .thr_irq_en (thr_irq_en),
  .eos_irq_en (eos_irq_en),
  .irq        (irq),
  .cnt        (smp_cnt)
);

// File: tb/sim_smpl_fifo.sv
module sim_smpl_fifo;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acq_run, smp_valid, scan_end, fifo_clr, dat_wr, dat_rd, sts_rd;
  logic        thr_irq_en, eos_irq_en, irq;
  logic [15:0] smp_data;
  logic [7:0]  dat_wdata, dat_rdata, sts_byte;

  always #10 clk = ~clk;

  smpl_fifo u0 (
    .clk(clk), .rst_n(rst_n), .acq_run(acq_run), .smp_valid(smp_valid),
    .smp_data(smp_data), .scan_end(scan_end), .fifo_clr(fifo_clr),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd),
    .dat_rdata(dat_rdata), .sts_rd(sts_rd), .sts_byte(sts_byte),
    .thr_irq_en(thr_irq_en), .eos_irq_en(eos_irq_en), .irq(irq)
  );

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  bit          done  = 1'b0;
  logic [7:0]  exp_q[$];
  event        rd_ev;
  string       rd_req;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard for every host byte read
  always begin
    @(rd_ev);
    #1;
    if (exp_q.size() == 0) begin
      n_chk++;
      n_err++;
      $display("FAIL %s: actual=%0h expected=<none queued>", rd_req, dat_rdata);
    end else begin
      chk(rd_req, 32'(dat_rdata), 32'(exp_q.pop_front()));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [15:0] d, input bit keep);
    smp_valid = 1'b1;
    smp_data  = d;
    if (keep) begin
      exp_q.push_back(d[7:0]);
      exp_q.push_back(d[15:8]);
    end
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic rd(input string req);
    rd_req = req;
    ->rd_ev;
    dat_rd = 1'b1;
    @(negedge clk);
    dat_rd = 1'b0;
  endtask

  task automatic peek(input string req, input logic [7:0] mask, input logic [7:0] exp);
    chk(req, 32'(sts_byte & mask), 32'(exp & mask));
  endtask

  task automatic sts_read();
    sts_rd = 1'b1;
    @(negedge clk);
    sts_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    dat_wr    = 1'b1;
    dat_wdata = b;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic load(input logic [15:0] ne, input logic [15:0] nf);
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    exp_q.delete();
    wr(ne[7:0]);
    wr(ne[15:8]);
    wr(nf[7:0]);
    wr(nf[15:8]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; acq_run = 1'b0; smp_valid = 1'b0; scan_end = 1'b0;
    fifo_clr = 1'b0; dat_wr = 1'b0; dat_rd = 1'b0; sts_rd = 1'b0;
    thr_irq_en = 1'b0; eos_irq_en = 1'b0; smp_data = '0; dat_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    peek("R1 status after reset", 8'hFF, 8'h81);
    chk("R1 irq after reset", 32'(irq), 0);

    // R10 run bits
    acq_run = 1'b1;
    tick(1);
    peek("R10 running bits", 8'hC0, 8'h40);

    // R4/R5/R6: threshold 4086 free bytes -> level at 10 stored bytes
    load(16'h0000, 16'd4086);
    for (int i = 0; i < 4; i++) push(16'h1100 + 16'(i), 1'b1);
    tick(2);
    peek("R5 below threshold", 8'h0A, 8'h00);
    push(16'h2244, 1'b1);
    tick(2);
    peek("R6 level and event at threshold", 8'h0A, 8'h0A);
    chk("R9 irq masked", 32'(irq), 0);
    thr_irq_en = 1'b1;
    tick(1);
    chk("R9 irq threshold enabled", 32'(irq), 1);
    sts_read();
    peek("R7 event cleared level kept", 8'h0E, 8'h02);
    chk("R9 irq after clear", 32'(irq), 0);

    // R5 half-read sample counts as one byte; R2 order
    rd("R2 low byte first");
    tick(1);
    peek("R5 half read frees one byte", 8'h02, 8'h00);
    rd("R2 high byte second");
    for (int i = 0; i < 8; i++) rd("R2 sample order");
    peek("R10 empty after drain", 8'h01, 8'h01);

    // R11 read on empty ignored
    dat_rd = 1'b1;
    tick(1);
    dat_rd = 1'b0;
    push(16'hA55A, 1'b1);
    rd("R11 after empty read low");
    rd("R11 after empty read high");
    peek("R11 empty again", 8'h01, 8'h01);

    // R4 extra writes ignored, near-empty bytes no effect
    load(16'h1234, 16'd4094);
    wr(8'hFF);
    wr(8'hFF);
    tick(2);
    peek("R4 extra writes ignored", 8'h0A, 8'h00);
    push(16'h0F0F, 1'b1);
    tick(2);
    peek("R4 near-full count loaded", 8'h0A, 8'h0A);
    sts_read();
    rd("R2 low");
    rd("R2 high");
    thr_irq_en = 1'b0;

    // R8 / R7 race / R9 end of scan
    scan_end = 1'b1;
    tick(1);
    scan_end = 1'b0;
    peek("R8 end of scan set", 8'h10, 8'h10);
    chk("R9 eos masked", 32'(irq), 0);
    eos_irq_en = 1'b1;
    tick(1);
    chk("R9 eos enabled", 32'(irq), 1);
    sts_rd = 1'b1;
    scan_end = 1'b1;
    tick(1);
    sts_rd = 1'b0;
    scan_end = 1'b0;
    peek("R7 event wins over read", 8'h10, 8'h10);
    sts_read();
    peek("R7 cleared by read", 8'h38, 8'h00);
    chk("R9 irq dropped", 32'(irq), 0);
    eos_irq_en = 1'b0;

    // R12 clear discards data
    for (int i = 0; i < 3; i++) push(16'h7000 + 16'(i), 1'b1);
    fifo_clr = 1'b1;
    tick(1);
    fifo_clr = 1'b0;
    exp_q.delete();
    peek("R12 clear empties", 8'h07, 8'h01);

    // R3 capacity, drop and data lost
    load(16'h0000, 16'h0000);
    for (int i = 0; i < 2047; i++) push(16'(i * 37 + 5), 1'b1);
    tick(2);
    peek("R3 not full at 2047", 8'h25, 8'h00);
    push(16'hBEEF, 1'b1);
    tick(1);
    peek("R3 full at 2048", 8'h05, 8'h04);
    push(16'hDEAD, 1'b0);
    tick(1);
    peek("R3 overflow sets lost", 8'h24, 8'h24);
    sts_read();
    for (int i = 0; i < 4096; i++) rd("R3 dropped sample absent");
    tick(1);
    peek("R3 drained", 8'h05, 8'h01);
    chk("R3 scoreboard drained", 32'(exp_q.size()), 0);

    acq_run = 1'b0;
    tick(1);
    peek("R10 idle bits", 8'hC0, 8'h80);

    finish_run();
  end
endmodule